// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address for a load or store and, in the same step, the value that the base register should take afterwards. It takes a base value, an offset that has already been chosen (an immediate or a register value, with any shifting done upstream), a two-bit indexing mode and a direction bit. It returns three things: the address to place on the bus, a write-back enable, and the updated base value.

The offset path replaces the separate add instruction that would otherwise be needed to form the address. The indexing modes differ in two ways: whether the bus sees the sum or the unmodified base, and whether the base register is written back.

All results are registered. They appear one clock after the input strobe, together with an output valid flag. When no request is present, the address outputs keep their last values and the write-back enable stays low.

Top module: `ldst_addr_gen`

## Requirements
- R1: While reset (`rst_n` low) is applied and after it is released with no request, `out_valid` and `wb_en` are 0 and `eff_addr` and `new_base` are 0.
- R2: A request sampled with `in_valid` high at a rising clock edge produces `out_valid` high for exactly the following cycle. Back-to-back requests produce back-to-back results.
- R3: Mode code 2'b00 (indirect) gives `eff_addr` = base and `new_base` = base, with `wb_en` = 0. The offset and direction bit have no effect.
- R4: Mode code 2'b01 (pre-indexed) gives `eff_addr` = base ± offset and `new_base` = base, with `wb_en` = 0.
- R5: Mode code 2'b10 (pre-indexed with update) gives `eff_addr` = `new_base` = base ± offset, with `wb_en` = 1.
- R6: Mode code 2'b11 (post-indexed) gives `eff_addr` = base and `new_base` = base ± offset, with `wb_en` = 1.
- R7: `offset_sub` = 0 adds the offset to the base, and `offset_sub` = 1 subtracts it.
- R8: Address arithmetic wraps modulo 2^32 in both directions, and no overflow indication is produced.
- R9: In a cycle following one with `in_valid` low, `out_valid` and `wb_en` are 0, and `eff_addr` and `new_base` keep their previous values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| base_val | input | 32 | Current base register value |
| offset_val | input | 32 | Offset, already selected and shifted |
| mode | input | 2 | Indexing mode: 00 indirect, 01 pre, 10 pre with update, 11 post |
| offset_sub | input | 1 | 1 subtracts the offset, 0 adds it |
| out_valid | output | 1 | Results valid this cycle |
| eff_addr | output | 32 | Address for the memory bus |
| wb_en | output | 1 | Base register write-back request |
| new_base | output | 32 | Value to write back to the base register |

## Verification
Two results come out in the same cycle: the bus address and the base update. In the updating modes both depend on one shared sum. In pre-indexed with update the two outputs must be equal. In post-indexed they must differ by exactly the offset, and the bus must still carry the old base. The vector table drives each mode with both directions and with wrapping sums, and the bench compares both outputs and the enable in one sample. Back-to-back requests with different modes check that one request's update does not leak into the next request's address.

// File: rtl/ldst_agu_pkg.sv
package ldst_agu_pkg;

  typedef enum logic [1:0] {
    AM_INDIRECT = 2'b00,
    AM_PRE      = 2'b01,
    AM_PRE_WB   = 2'b10,
    AM_POST     = 2'b11
  } agu_mode_e;

  // Modes that request a base register update.
  function automatic logic mode_updates_base(agu_mode_e m);
    return (m == AM_PRE_WB) || (m == AM_POST);
  endfunction

  // Modes whose bus address includes the offset.
  function automatic logic mode_bus_uses_sum(agu_mode_e m);
    return (m == AM_PRE) || (m == AM_PRE_WB);
  endfunction

endpackage

// File: rtl/agu_offset_adder.sv
module agu_offset_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] offset_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o
);

  // Two's complement add or subtract; the carry out is dropped, so the result wraps.
  function automatic logic [W-1:0] apply_offset(logic [W-1:0] b, logic [W-1:0] o, logic s);
    logic [W-1:0] operand;
    operand = s ? ~o : o;
    return b + operand + {{(W-1){1'b0}}, s};
  endfunction

  assign sum_o = apply_offset(base_i, offset_i, sub_i);

endmodule

// File: rtl/agu_mode_select.sv
module agu_mode_select
  import ldst_agu_pkg::*;
#(
  parameter int W = 32
) (
  input  agu_mode_e    mode_i,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] sum_i,
  output logic [W-1:0] ea_o,
  output logic [W-1:0] nb_o,
  output logic         wb_o
);

  always_comb begin
    ea_o = mode_bus_uses_sum(mode_i) ? sum_i : base_i;
    wb_o = mode_updates_base(mode_i);
    nb_o = wb_o ? sum_i : base_i;
  end

endmodule

// File: rtl/agu_out_reg.sv
module agu_out_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] ea_d,
  input  logic [W-1:0] nb_d,
  input  logic         wb_d,
  output logic         vld_q,
  output logic [W-1:0] ea_q,
  output logic [W-1:0] nb_q,
  output logic         wb_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      wb_q  <= 1'b0;
      ea_q  <= '0;
      nb_q  <= '0;
    end else begin
      vld_q <= load_i;
      wb_q  <= load_i & wb_d;
      if (load_i) begin
        ea_q <= ea_d;
        nb_q <= nb_d;
      end
    end
  end

endmodule

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen
  import ldst_agu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] offset_val,
  input  logic [1:0]        mode,
  input  logic              offset_sub,
  output logic              out_valid,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              wb_en,
  output logic [ADDR_W-1:0] new_base
);

  agu_mode_e         mode_e;
  logic [ADDR_W-1:0] sum_w;
  logic [ADDR_W-1:0] ea_w;
  logic [ADDR_W-1:0] nb_w;
  logic              wb_w;

  assign mode_e = agu_mode_e'(mode);

  agu_offset_adder #(.W(ADDR_W)) u_adder (
    .base_i   (base_val),
    .offset_i (offset_val),
    .sub_i    (offset_sub),
    .sum_o    (sum_w)
  );

  agu_mode_select #(.W(ADDR_W)) u_sel (
    .mode_i (mode_e),
    .base_i (base_val),
    .sum_i  (sum_w),
    .ea_o   (ea_w),
    .nb_o   (nb_w),
    .wb_o   (wb_w)
  );

  agu_out_reg #(.W(ADDR_W)) u_oreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (in_valid),
    .ea_d   (ea_w),
    .nb_d   (nb_w),
    .wb_d   (wb_w),
    .vld_q  (out_valid),
    .ea_q   (eff_addr),
    .nb_q   (new_base),
    .wb_q   (wb_en)
  );

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !wb_en && $stable(eff_addr) && $stable(new_base)));

  assert_indirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b00) |=>
      (eff_addr == $past(base_val) && new_base == $past(base_val) && !wb_en));

  assert_pre_keeps_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b01) |=> (new_base == $past(base_val) && !wb_en));

  assert_prewb_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b10) |=> (eff_addr == new_base && wb_en));

  assert_post_old_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b11) |=> (eff_addr == $past(base_val) && wb_en));

endmodule

// File: tb/ldst_addr_gen_tb.sv
`timescale 1ns/1ps
module ldst_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] base_val = '0;
  logic [31:0] offset_val = '0;
  logic [1:0]  mode = 2'b00;
  logic        offset_sub = 1'b0;
  logic        out_valid;
  logic [31:0] eff_addr;
  logic        wb_en;
  logic [31:0] new_base;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ldst_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_val(base_val),
    .offset_val(offset_val), .mode(mode), .offset_sub(offset_sub),
    .out_valid(out_valid), .eff_addr(eff_addr), .wb_en(wb_en), .new_base(new_base)
  );

  // Entry: {mode, sub, base, offset, exp_ea, exp_nb, exp_wb}
  localparam int NV = 10;
  localparam logic [131:0] VEC [NV] = '{
    {2'b00, 1'b0, 32'h0000_1000, 32'h0000_0004, 32'h0000_1000, 32'h0000_1000, 1'b0},
    {2'b01, 1'b0, 32'h0000_1000, 32'h0000_0004, 32'h0000_1004, 32'h0000_1000, 1'b0},
    {2'b10, 1'b0, 32'h0000_2000, 32'h0000_0010, 32'h0000_2010, 32'h0000_2010, 1'b1},
    {2'b11, 1'b0, 32'h0000_3000, 32'h0000_0008, 32'h0000_3000, 32'h0000_3008, 1'b1},
    {2'b01, 1'b1, 32'h0000_1000, 32'h0000_0004, 32'h0000_0FFC, 32'h0000_1000, 1'b0},
    {2'b10, 1'b1, 32'h0000_0100, 32'h0000_0020, 32'h0000_00E0, 32'h0000_00E0, 1'b1},
    {2'b11, 1'b1, 32'h0000_0040, 32'h0000_0040, 32'h0000_0040, 32'h0000_0000, 1'b1},
    {2'b10, 1'b0, 32'hFFFF_FFFC, 32'h0000_0008, 32'h0000_0004, 32'h0000_0004, 1'b1},
    {2'b11, 1'b1, 32'h0000_0000, 32'h0000_0001, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1},
    {2'b00, 1'b1, 32'hDEAD_BEEF, 32'h0000_0123, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0}
  };

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] m, logic s, logic [31:0] b, logic [31:0] o);
    in_valid = 1'b1; mode = m; offset_sub = s; base_val = b; offset_val = o;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "out_valid", {31'd0, out_valid}, 32'd0);
    check("R1", "wb_en", {31'd0, wb_en}, 32'd0);
    check("R1", "eff_addr", eff_addr, 32'd0);
    check("R1", "new_base", new_base, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "out_valid after release", {31'd0, out_valid}, 32'd0);

    // Vector walk: each mode, both directions (R7), wrapping sums (R8)
    for (int i = 0; i < NV; i++) begin
      logic [131:0] v;
      v = VEC[i];
      drive(v[131:130], v[129], v[128:97], v[96:65]);
      @(negedge clk);
      in_valid = 1'b0;
      check("R2", "out_valid", {31'd0, out_valid}, 32'd1);
      check(mode_tag(v[131:130]), "eff_addr (R7/R8)", eff_addr, v[64:33]);
      check(mode_tag(v[131:130]), "new_base (R7/R8)", new_base, v[32:1]);
      check(mode_tag(v[131:130]), "wb_en", {31'd0, wb_en}, {31'd0, v[0]});
    end

    // R9: idle cycles keep outputs and drop enables, even with inputs moving
    @(negedge clk);
    base_val = 32'h5555_AAAA; offset_val = 32'h1; mode = 2'b10;
    @(negedge clk);
    check("R9", "out_valid idle", {31'd0, out_valid}, 32'd0);
    check("R9", "wb_en idle", {31'd0, wb_en}, 32'd0);
    check("R9", "eff_addr held", eff_addr, 32'hDEAD_BEEF);
    check("R9", "new_base held", new_base, 32'hDEAD_BEEF);

    // R2: back-to-back, post then pre-indexed: update must not leak into next address
    drive(2'b11, 1'b0, 32'h0000_8000, 32'h0000_0100);
    @(negedge clk);
    check("R6", "b2b post ea", eff_addr, 32'h0000_8000);
    check("R6", "b2b post nb", new_base, 32'h0000_8100);
    drive(2'b01, 1'b0, 32'h0000_8000, 32'h0000_0020);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", "b2b second valid", {31'd0, out_valid}, 32'd1);
    check("R4", "b2b pre ea", eff_addr, 32'h0000_8020);
    check("R4", "b2b pre nb", new_base, 32'h0000_8000);
    check("R4", "b2b pre wb", {31'd0, wb_en}, 32'd0);
    @(negedge clk);
    check("R2", "single-cycle valid", {31'd0, out_valid}, 32'd0);

    // R8: add wrapping exactly to zero
    drive(2'b01, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", "wrap to zero", eff_addr, 32'h0000_0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule